// File: doc/BRIEF.md
# Peer-to-Peer Request Routing Filter

This block sits in an on-chip fabric on the upstream request path. For each memory request it makes one of three choices: pass the request on to system memory, pass it to a peer agent, or master-abort it. A peer agent is another root port or an integrated endpoint. A separate target decoder classifies the request address and presents the class to this block alongside the request. The filter then decides from the request's source, the request kind and a set of per-root-port peer enables. Software programs those enables through a small register port, and a one-way lock can freeze them.

Sources 0 to 3 are root ports. Sources 4 to 7 are other upstream controllers, such as legacy or low-pin-count bridges, and these may only reach system memory. A forwarded request is registered and held until the selected target accepts it. An aborted request produces a one-cycle unsupported-request completion back to the requester.

Top module: `p2p_route_filter`

## Requirements
- R1: A request whose decoded class is system memory (`dec_class`=0) is forwarded with `fwd_route`=0 for every source and every request kind, whatever the enable bits hold.
- R2: A root-port source (`req_src`<4) with a memory read (`req_kind`=0) or memory write (`req_kind`=1) aimed at a root port (`dec_class`=1) or an integrated endpoint (`dec_class`=2) is forwarded when that source's enable bit (bit `req_src` of the enable register) is 1. It then carries `fwd_route`=1 or 2 respectively and `fwd_port`=`dec_port`.
- R3: The same peer request is aborted when the source's enable bit is 0.
- R4: A peer-targeted request of any kind other than memory read or write (`req_kind`=2 or 3) is aborted even when the enable bit is 1.
- R5: A request from a non-root-port source (`req_src`>=4) aimed at a peer class is aborted and never forwarded.
- R6: A request whose class is unmapped (`dec_class`=3) is aborted for every source.
- R7: An abort raises `cpl_valid` for exactly the one cycle after acceptance, with `cpl_status`=3'b001 (unsupported request), `cpl_src` equal to the requester, and no forward.
- R8: A forward appears in the cycle after acceptance and holds `fwd_valid` and its fields stable until `fwd_ready` is high at a clock edge. `req_ready` stays low while a forward is held.
- R9: After reset the enable register (`cfg_addr`=0) and the lock register (`cfg_addr`=1, bit 0) both read 0. While unlocked, a write to address 0 stores `cfg_wdata`, and `cfg_rdata` returns the addressed register combinationally.
- R10: Writing any nonzero value to address 1 sets the lock. Writing zero has no effect, and only reset clears the lock.
- R11: While the lock is set, writes to the enable register are ignored and readback returns the value stored before.
- R12: A root port whose request targets its own port number is treated as peer traffic and gated by its own enable bit.
- R13: When an enable write and a request acceptance fall on the same clock edge, the request is judged with the enable value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Filter can accept a request |
| req_src | input | 3 | Source ID; 0-3 root ports, 4-7 other controllers |
| req_kind | input | 2 | 0 memory read, 1 memory write, 2 I/O, 3 configuration |
| req_addr | input | ADDR_W | Request address |
| dec_class | input | 2 | 0 system memory, 1 root port, 2 integrated endpoint, 3 unmapped |
| dec_port | input | 2 | Target port or endpoint index from the decoder |
| fwd_valid | output | 1 | Forwarded request present |
| fwd_ready | input | 1 | Selected target accepts the forward |
| fwd_route | output | 2 | 0 memory, 1 root port, 2 integrated endpoint |
| fwd_port | output | 2 | Target index |
| fwd_src | output | 3 | Source ID of the forwarded request |
| fwd_kind | output | 2 | Kind of the forwarded request |
| fwd_addr | output | ADDR_W | Address of the forwarded request |
| cpl_valid | output | 1 | Abort completion pulse |
| cpl_status | output | 3 | 3'b001 on abort, 0 otherwise |
| cpl_src | output | 3 | Requester receiving the completion |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 enable register, 1 lock register |
| cfg_wdata | input | 4 | Register write data |
| cfg_rdata | output | 4 | Addressed register readback |

## Verification
Two things can share one clock edge: a register write that changes an enable bit, and the acceptance of a request that this bit governs. The bench drives both on the same edge, once turning a bit on and once turning it off. It judges the request against the old value: the first request is aborted and the second is forwarded. It then repeats the request alone to confirm that the new value took effect. A second test overlaps a locked-state enable write with readback, to show that the frozen value survives.

// File: rtl/p2p_route_filter.sv
module p2p_route_filter #(
  parameter int ADDR_W = 32,
  parameter int NUM_RP = 4,
  parameter int SRC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        dec_class,
  input  logic [1:0]        dec_port,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [1:0]        fwd_route,
  output logic [1:0]        fwd_port,
  output logic [SRC_W-1:0]  fwd_src,
  output logic [1:0]        fwd_kind,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              cpl_valid,
  output logic [2:0]        cpl_status,
  output logic [SRC_W-1:0]  cpl_src,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [NUM_RP-1:0] cfg_wdata,
  output logic [NUM_RP-1:0] cfg_rdata
);
  localparam int PORT_W = $clog2(NUM_RP);
  localparam logic [SRC_W-1:0] RP_LIMIT = SRC_W'(NUM_RP);
  localparam logic [1:0] CLS_SYS = 2'd0, CLS_RP = 2'd1, CLS_EP = 2'd2;
  localparam logic [1:0] KIND_RD = 2'd0, KIND_WR = 2'd1;
  localparam logic [1:0] ROUTE_MEM = 2'd0;
  localparam logic [2:0] ST_UR = 3'b001;

  logic [NUM_RP-1:0] en_q;
  logic              lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      lock_q <= 1'b0;
    end else if (cfg_we) begin
      if (!cfg_addr && !lock_q) en_q <= cfg_wdata;
      if (cfg_addr && |cfg_wdata) lock_q <= 1'b1;
    end
  end

  assign cfg_rdata = cfg_addr ? {{(NUM_RP-1){1'b0}}, lock_q} : en_q;

  logic accept, src_is_rp, kind_mem, to_peer, peer_ok, go_fwd;
  logic [PORT_W-1:0] src_idx;

  assign req_ready = !fwd_valid;
  assign accept    = req_valid && req_ready;
  assign src_is_rp = req_src < RP_LIMIT;
  assign src_idx   = req_src[PORT_W-1:0];
  assign kind_mem  = (req_kind == KIND_RD) || (req_kind == KIND_WR);
  assign to_peer   = (dec_class == CLS_RP) || (dec_class == CLS_EP);
  assign peer_ok   = src_is_rp && kind_mem && en_q[src_idx];
  assign go_fwd    = (dec_class == CLS_SYS) || (to_peer && peer_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_route <= '0;
      fwd_port  <= '0;
      fwd_src   <= '0;
      fwd_kind  <= '0;
      fwd_addr  <= '0;
      cpl_valid <= 1'b0;
      cpl_src   <= '0;
    end else begin
      cpl_valid <= accept && !go_fwd;
      if (accept && !go_fwd) cpl_src <= req_src;
      if (accept && go_fwd) begin
        fwd_valid <= 1'b1;
        fwd_route <= dec_class;
        fwd_port  <= dec_port;
        fwd_src   <= req_src;
        fwd_kind  <= req_kind;
        fwd_addr  <= req_addr;
      end else if (fwd_valid && fwd_ready) begin
        fwd_valid <= 1'b0;
      end
    end
  end

  assign cpl_status = cpl_valid ? ST_UR : 3'b000;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> lock_q); // R10
  AST_EN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) lock_q |=> $stable(en_q)); // R11
  AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fwd_ready |=> fwd_valid && $stable(fwd_addr) && $stable(fwd_route) && $stable(fwd_src)); // R8
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(fwd_valid && cpl_valid)); // R7
  AST_CPL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> $past(req_valid && req_ready)); // R7
  AST_PEER_RP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && fwd_route != ROUTE_MEM |-> fwd_src < RP_LIMIT); // R5
endmodule

// File: tb/test_p2p_route_filter.sv
`timescale 1ns/1ps
module test_p2p_route_filter;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [2:0] req_src = 0;
  logic [1:0] req_kind = 0;
  logic [31:0] req_addr = 0;
  logic [1:0] dec_class = 0, dec_port = 0;
  logic fwd_valid, fwd_ready = 1;
  logic [1:0] fwd_route, fwd_port, fwd_kind;
  logic [2:0] fwd_src;
  logic [31:0] fwd_addr;
  logic cpl_valid;
  logic [2:0] cpl_status, cpl_src;
  logic cfg_we = 0, cfg_addr = 0;
  logic [3:0] cfg_wdata = 0, cfg_rdata;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  p2p_route_filter i_p2p_route_filter (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] s, input logic [1:0] k, input logic [1:0] c,
                      input logic [1:0] p, input logic [31:0] a);
    @(negedge clk);
    req_src = s; req_kind = k; dec_class = c; dec_port = p; req_addr = a; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_abort(input string tag, input logic [2:0] s);
    chk({tag, " cpl_valid"}, cpl_valid, 1);
    chk({tag, " cpl_status"}, cpl_status, 3'b001);
    chk({tag, " cpl_src"}, cpl_src, s);
    chk({tag, " no fwd"}, fwd_valid, 0);
    @(negedge clk);
    chk({tag, " cpl pulse"}, cpl_valid, 0);
  endtask

  task automatic expect_fwd(input string tag, input logic [1:0] r, input logic [1:0] p,
                            input logic [2:0] s, input logic [31:0] a);
    chk({tag, " fwd_valid"}, fwd_valid, 1);
    chk({tag, " fwd_route"}, fwd_route, r);
    chk({tag, " fwd_port"}, fwd_port, p);
    chk({tag, " fwd_src"}, fwd_src, s);
    chk({tag, " fwd_addr"}, fwd_addr, a);
    chk({tag, " no cpl"}, cpl_valid, 0);
    @(negedge clk);
    chk({tag, " fwd drained"}, fwd_valid, 0);
  endtask

  task automatic cfg_write(input logic a, input logic [3:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_expect(input string tag, input logic a, input logic [3:0] d);
    cfg_addr = a;
    #0.5;
    chk(tag, cfg_rdata, d);
  endtask

  task automatic t_reset;
    cfg_expect("R9 reset enable", 0, 4'h0);
    cfg_expect("R9 reset lock", 1, 4'h0);
    chk("R8 reset ready", req_ready, 1);
    chk("R7 reset cpl", cpl_valid, 0);
  endtask

  task automatic t_sysmem;
    send(3'd0, 2'd0, 2'd0, 2'd0, 32'h1000); expect_fwd("R1 rp rd mem", 2'd0, 2'd0, 3'd0, 32'h1000);
    send(3'd5, 2'd1, 2'd0, 2'd0, 32'h2000); expect_fwd("R1 legacy wr mem", 2'd0, 2'd0, 3'd5, 32'h2000);
    send(3'd2, 2'd2, 2'd0, 2'd0, 32'h3000); expect_fwd("R1 io mem", 2'd0, 2'd0, 3'd2, 32'h3000);
  endtask

  task automatic t_peer_disabled;
    send(3'd1, 2'd0, 2'd1, 2'd2, 32'h4000); expect_abort("R3 rp1 disabled to rp", 3'd1);
    send(3'd3, 2'd1, 2'd2, 2'd1, 32'h4100); expect_abort("R3 rp3 disabled to ep", 3'd3);
  endtask

  task automatic t_peer_enabled;
    cfg_write(0, 4'b0110);
    cfg_expect("R9 enable readback", 0, 4'b0110);
    send(3'd1, 2'd0, 2'd1, 2'd3, 32'h5000); expect_fwd("R2 rp1 rd to rp", 2'd1, 2'd3, 3'd1, 32'h5000);
    send(3'd2, 2'd1, 2'd2, 2'd1, 32'h5100); expect_fwd("R2 rp2 wr to ep", 2'd2, 2'd1, 3'd2, 32'h5100);
    send(3'd0, 2'd0, 2'd1, 2'd1, 32'h5200); expect_abort("R3 rp0 still off", 3'd0);
    send(3'd2, 2'd2, 2'd1, 2'd0, 32'h5300); expect_abort("R4 io to peer", 3'd2);
    send(3'd1, 2'd3, 2'd2, 2'd0, 32'h5400); expect_abort("R4 cfg to peer", 3'd1);
    send(3'd1, 2'd0, 2'd1, 2'd1, 32'h5500); expect_fwd("R12 self target on", 2'd1, 2'd1, 3'd1, 32'h5500);
    send(3'd0, 2'd0, 2'd1, 2'd0, 32'h5600); expect_abort("R12 self target off", 3'd0);
  endtask

  task automatic t_nonrp_unmapped;
    cfg_write(0, 4'b1111);
    send(3'd4, 2'd0, 2'd1, 2'd0, 32'h6000); expect_abort("R5 legacy to rp", 3'd4);
    send(3'd7, 2'd1, 2'd2, 2'd0, 32'h6100); expect_abort("R5 lpc to ep", 3'd7);
    send(3'd2, 2'd0, 2'd3, 2'd0, 32'h6200); expect_abort("R6 rp unmapped", 3'd2);
    send(3'd6, 2'd0, 2'd3, 2'd0, 32'h6300); expect_abort("R6 legacy unmapped", 3'd6);
  endtask

  task automatic t_hold;
    fwd_ready = 0;
    send(3'd3, 2'd1, 2'd1, 2'd0, 32'h7000);
    for (int i = 0; i < 3; i++) begin
      chk("R8 held valid", fwd_valid, 1);
      chk("R8 held addr", fwd_addr, 32'h7000);
      chk("R8 ready low", req_ready, 0);
      @(negedge clk);
    end
    fwd_ready = 1;
    @(negedge clk);
    chk("R8 released", fwd_valid, 0);
    chk("R8 ready back", req_ready, 1);
  endtask

  task automatic t_same_edge;
    cfg_write(0, 4'b0000);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 0; cfg_wdata = 4'b0001;
    req_src = 0; req_kind = 0; dec_class = 2'd1; dec_port = 2'd2; req_addr = 32'h8000; req_valid = 1;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    expect_abort("R13 on-write uses old 0", 3'd0);
    send(3'd0, 2'd0, 2'd1, 2'd2, 32'h8100); expect_fwd("R13 new value 1", 2'd1, 2'd2, 3'd0, 32'h8100);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 0; cfg_wdata = 4'b0000;
    req_src = 0; req_kind = 1; dec_class = 2'd2; dec_port = 2'd0; req_addr = 32'h8200; req_valid = 1;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    expect_fwd("R13 off-write uses old 1", 2'd2, 2'd0, 3'd0, 32'h8200);
    send(3'd0, 2'd0, 2'd2, 2'd0, 32'h8300); expect_abort("R13 new value 0", 3'd0);
  endtask

  task automatic t_lock;
    cfg_write(0, 4'b1010);
    cfg_write(1, 4'b0000);
    cfg_expect("R10 zero write no lock", 1, 4'h0);
    cfg_write(1, 4'b0100);
    cfg_expect("R10 lock set", 1, 4'h1);
    cfg_write(0, 4'b0101);
    cfg_expect("R11 enable frozen", 0, 4'b1010);
    cfg_write(1, 4'b0000);
    cfg_expect("R10 lock sticky", 1, 4'h1);
    send(3'd1, 2'd0, 2'd1, 2'd0, 32'h9000); expect_fwd("R11 frozen bit1 on", 2'd1, 2'd0, 3'd1, 32'h9000);
    send(3'd0, 2'd0, 2'd1, 2'd3, 32'h9100); expect_abort("R11 frozen bit0 off", 3'd0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    cfg_expect("R10 reset clears lock", 1, 4'h0);
    cfg_expect("R9 reset clears enable", 0, 4'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sysmem();
    t_peer_disabled();
    t_peer_enabled();
    t_nonrp_unmapped();
    t_hold();
    t_same_edge();
    t_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule